// File: doc/BRIEF.md
# Configurable-frame UART transmitter

This block turns bytes into asynchronous serial frames on one TX line. A producer pushes bytes into a 16-entry transmit queue through a simple write strobe. The queue reports when it is full, and it raises a one-cycle flag whenever a write is lost. The transmitter pulls one byte at a time from the queue. It sends each byte as a start bit, 5 to 8 data bits with the least significant bit first, an optional parity bit, and then 1, 1.5 or 2 stop bits.

The frame format comes from one packed 8-bit line-control input. A 16-bit baud divisor sets the rate of a bit-timing enable that runs at 16 times the bit rate, so every bit lasts sixteen enables. A break control forces the line low without disturbing the frame timing. An idle output reports when the queue is empty and the shifter has finished its last stop bit.

Top module: `uart_frame_tx`

## Requirements
- R1: The line idles high. Each frame is one low start bit, then the data bits least significant bit first, then the optional parity bit, then high stop bits.
- R2: line_ctrl[1:0] sets the data length. The values 0, 1, 2 and 3 give 5, 6, 7 and 8 data bits.
- R3: With line_ctrl[2] clear, the stop time is 16 enables. With line_ctrl[2] set, it is 24 enables for 5-bit frames and 32 enables for longer frames. When the queue still holds a byte at the end of the stop time, the next start bit begins at once.
- R4: line_ctrl[3] set inserts a parity bit. With line_ctrl[4] set, the parity bit makes the total count of ones among data and parity even. With line_ctrl[4] clear, that count is odd.
- R5: line_ctrl[5] set together with line_ctrl[3] makes the parity bit a constant: 0 when line_ctrl[4] is set and 1 when it is clear.
- R6: While line_ctrl[6] is set, tx is low. The frame in progress keeps its bit timing, so the bits after the break is released appear in their normal slots.
- R7: Every bit lasts 16 × baud_div clock cycles. A baud_div of 0 acts as 1.
- R8: The queue holds 16 bytes and sends them in write order. fifo_full is high while 16 bytes wait. A write while full is dropped, and wr_drop pulses high in the next cycle.
- R9: tx_idle is high exactly when no byte waits and no frame is on the line. It rises in the cycle the last stop bit ends.
- R10: While line_ctrl[7] is set, the bit-timing enable is held off. No frame starts or advances. Clearing the bit lets the waiting byte go out normally.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Push strobe for the transmit queue |
| wr_data | input | 8 | Byte to push |
| fifo_full | output | 1 | Queue holds 16 bytes |
| wr_drop | output | 1 | One-cycle pulse after a write was lost to a full queue |
| line_ctrl | input | 8 | Frame format, break and timing hold |
| baud_div | input | 16 | Clock cycles per 16x enable (0 acts as 1) |
| tx | output | 1 | Serial output |
| tx_idle | output | 1 | Queue empty and line at rest |

## Verification
The bench sweeps all 64 frame formats and sends two bytes back to back for each one. It samples every bit slot in the middle, and it measures the distance between the two start edges. A wrong stop length for 5-bit frames, a swapped parity sense or a lost data bit therefore shows up as a bad sample or a wrong start-to-start distance. The break case releases the line in the middle of a frame. A design that resets or stalls its timing under break would put the later data bits and the idle rise in the wrong cycles. The queue is overfilled while one frame is already on the line, so an off-by-one depth, a lost ordering or a dropped write that still gets sent each changes the sequence of sent bytes. Divisors 0, 1, 2, 3 and 7 check the bit period, and a design that treats 0 as 65536 or stalls on it would time out.

// File: rtl/uart_frame_pkg.sv
// Package: shared types and helpers for the configurable-frame transmitter.
// Assumes: data bytes are 8 bits wide; shorter frames use the low bits.
package uart_frame_pkg;

    // Packed view of the line-control byte; bit positions are behaviour.
    typedef struct packed {
        logic       hold_timing;  // [7] freeze the bit-timing enable
        logic       force_break;  // [6] drive the line low
        logic       stick_par;    // [5] constant parity value
        logic       even_par;     // [4] even parity sense
        logic       par_on;       // [3] insert a parity bit
        logic       long_stop;    // [2] 1.5 or 2 stop bits
        logic [1:0] len_code;     // [1:0] 5..8 data bits
    } line_ctrl_t;

    typedef enum logic [2:0] {
        SH_IDLE,
        SH_START,
        SH_DATA,
        SH_PARITY,
        SH_STOP
    } shift_state_e;

    // Parity bit for a byte under a given length, sense and stick setting.
    function automatic logic frame_parity(
        input logic [7:0] data,
        input logic [1:0] len_code,
        input logic       even_par,
        input logic       stick_par
    );
        logic [7:0] mask;
        logic       ones_odd;
        mask     = 8'hFF >> (2'd3 - len_code);
        ones_odd = ^(data & mask);
        if (stick_par) begin
            return ~even_par;
        end
        return even_par ? ones_odd : ~ones_odd;
    endfunction

endpackage

// File: rtl/uft_tick_gen.sv
// Module: uft_tick_gen
// Produces a single-cycle enable every 'divisor' clocks (0 acts as 1).
// Assumes: divisor may change at any time; an overshooting count wraps at once.
// While hold is high the counter is parked at zero and no enable is produced.
module uft_tick_gen #(
    parameter int DIV_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             hold,
    input  logic [DIV_W-1:0] divisor,
    output logic             tick
);

    logic [DIV_W-1:0] eff_div;
    logic [DIV_W-1:0] cnt_q;
    logic             wrap;

    // Effective divisor: zero is promoted to one.
    always_comb begin
        eff_div = (divisor == '0) ? DIV_W'(1) : divisor;
        wrap    = (cnt_q >= eff_div - DIV_W'(1));
    end

    // Count clocks and emit the enable on wrap.
    always_ff @(posedge clk) begin
        if (!rst_n || hold) begin
            cnt_q <= '0;
            tick  <= 1'b0;
        end else if (wrap) begin
            cnt_q <= '0;
            tick  <= 1'b1;
        end else begin
            cnt_q <= cnt_q + DIV_W'(1);
            tick  <= 1'b0;
        end
    end

endmodule

// File: rtl/uft_fifo.sv
// Module: uft_fifo
// Synchronous queue with a head read port visible without a pop.
// Assumes: DEPTH is a power of two; a write while full is dropped and flagged
// one cycle later; pop is only requested while not empty.
module uft_fifo #(
    parameter int WIDTH = 8,
    parameter int DEPTH = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [WIDTH-1:0] wr_data,
    input  logic             pop,
    output logic [WIDTH-1:0] rd_data,
    output logic             empty,
    output logic             full,
    output logic             drop
);

    localparam int AW = $clog2(DEPTH);
    localparam int CW = AW + 1;

    logic [WIDTH-1:0] mem [DEPTH];
    logic [AW-1:0]    wptr_q;
    logic [AW-1:0]    rptr_q;
    logic [CW-1:0]    count_q;
    logic             push;
    logic             take;

    // Status and accepted-operation decode.
    always_comb begin
        full    = (count_q == CW'(DEPTH));
        empty   = (count_q == '0);
        push    = wr_en && !full;
        take    = pop && !empty;
        rd_data = mem[rptr_q];
    end

    // Storage write.
    always_ff @(posedge clk) begin
        if (push) begin
            mem[wptr_q] <= wr_data;
        end
    end

    // Pointers, occupancy and drop flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wptr_q  <= '0;
            rptr_q  <= '0;
            count_q <= '0;
            drop    <= 1'b0;
        end else begin
            drop <= wr_en && full;
            if (push) begin
                wptr_q <= wptr_q + AW'(1);
            end
            if (take) begin
                rptr_q <= rptr_q + AW'(1);
            end
            case ({push, take})
                2'b10:   count_q <= count_q + CW'(1);
                2'b01:   count_q <= count_q - CW'(1);
                default: count_q <= count_q;
            endcase
        end
    end

endmodule

// File: rtl/uft_shifter.sv
// Module: uft_shifter
// Frame sequencer: start, data LSB first, optional parity, stop time.
// Assumes: 'tick' is the 16x enable; the frame format is captured when a byte
// is taken so mid-frame format changes affect only later frames. A new frame
// starts on the same enable that ends the previous stop time.
module uft_shifter
    import uart_frame_pkg::*;
#(
    parameter int OVS = 16
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       tick,
    input  logic [1:0] len_code,
    input  logic       long_stop,
    input  logic       par_on,
    input  logic       even_par,
    input  logic       stick_par,
    input  logic       fifo_empty,
    input  logic [7:0] fifo_data,
    output logic       pop,
    output logic       line,
    output logic       busy
);

    localparam int TCW       = $clog2(2 * OVS) + 1;
    localparam int HALF_OVS  = OVS / 2;
    localparam int STOP1_END = OVS - 1;
    localparam int STOPH_END = OVS + HALF_OVS - 1;
    localparam int STOP2_END = 2 * OVS - 1;

    shift_state_e state_q;
    logic [TCW-1:0] tcnt_q;
    logic [TCW-1:0] slot_end;
    logic [TCW-1:0] stop_end_q;
    logic [2:0]     bidx_q;
    logic [2:0]     last_bit_q;
    logic [7:0]     shreg_q;
    logic           par_bit_q;
    logic           par_on_q;
    logic           slot_done;
    logic           start_frame;

    // Slot length and frame-start decode.
    always_comb begin
        slot_end    = (state_q == SH_STOP) ? stop_end_q : TCW'(OVS - 1);
        slot_done   = tick && (tcnt_q == slot_end);
        start_frame = !fifo_empty && tick &&
                      ((state_q == SH_IDLE) || ((state_q == SH_STOP) && slot_done));
        pop         = start_frame;
        busy        = (state_q != SH_IDLE);
    end

    // Sequence the frame one slot at a time.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q    <= SH_IDLE;
            tcnt_q     <= '0;
            stop_end_q <= TCW'(STOP1_END);
            bidx_q     <= '0;
            last_bit_q <= '0;
            shreg_q    <= '0;
            par_bit_q  <= 1'b0;
            par_on_q   <= 1'b0;
            line       <= 1'b1;
        end else if (start_frame) begin
            state_q    <= SH_START;
            tcnt_q     <= '0;
            bidx_q     <= '0;
            shreg_q    <= fifo_data;
            last_bit_q <= {1'b0, len_code} + 3'd4;
            par_on_q   <= par_on;
            par_bit_q  <= frame_parity(fifo_data, len_code, even_par, stick_par);
            if (!long_stop) begin
                stop_end_q <= TCW'(STOP1_END);
            end else if (len_code == 2'd0) begin
                stop_end_q <= TCW'(STOPH_END);
            end else begin
                stop_end_q <= TCW'(STOP2_END);
            end
            line <= 1'b0;
        end else if (tick && (state_q != SH_IDLE)) begin
            if (!slot_done) begin
                tcnt_q <= tcnt_q + TCW'(1);
            end else begin
                tcnt_q <= '0;
                case (state_q)
                    SH_START: begin
                        state_q <= SH_DATA;
                        line    <= shreg_q[0];
                    end
                    SH_DATA: begin
                        if (bidx_q == last_bit_q) begin
                            if (par_on_q) begin
                                state_q <= SH_PARITY;
                                line    <= par_bit_q;
                            end else begin
                                state_q <= SH_STOP;
                                line    <= 1'b1;
                            end
                        end else begin
                            bidx_q  <= bidx_q + 3'd1;
                            shreg_q <= shreg_q >> 1;
                            line    <= shreg_q[1];
                        end
                    end
                    SH_PARITY: begin
                        state_q <= SH_STOP;
                        line    <= 1'b1;
                    end
                    default: begin
                        state_q <= SH_IDLE;
                        line    <= 1'b1;
                    end
                endcase
            end
        end
    end

endmodule

// File: rtl/uart_frame_tx.sv
// Module: uart_frame_tx (top)
// Queue, baud enable and frame sequencer for a configurable serial transmitter.
// Assumes: synchronous active-low reset; line_ctrl and baud_div are quasi-static
// except the break bit, which acts immediately on the line.
module uart_frame_tx
    import uart_frame_pkg::*;
#(
    parameter int DATA_W     = 8,
    parameter int DIV_W      = 16,
    parameter int FIFO_DEPTH = 16,
    parameter int OVS        = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    output logic              fifo_full,
    output logic              wr_drop,
    input  logic [7:0]        line_ctrl,
    input  logic [DIV_W-1:0]  baud_div,
    output logic              tx,
    output logic              tx_idle
);

    line_ctrl_t        lc;
    logic              tick_w;
    logic              pop_w;
    logic              empty_w;
    logic [DATA_W-1:0] head_w;
    logic              line_w;
    logic              busy_w;

    // Packed view of the control byte.
    always_comb lc = line_ctrl_t'(line_ctrl);

    uft_tick_gen #(
        .DIV_W (DIV_W)
    ) tick_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .hold    (lc.hold_timing),
        .divisor (baud_div),
        .tick    (tick_w)
    );

    uft_fifo #(
        .WIDTH (DATA_W),
        .DEPTH (FIFO_DEPTH)
    ) fifo_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_data (wr_data),
        .pop     (pop_w),
        .rd_data (head_w),
        .empty   (empty_w),
        .full    (fifo_full),
        .drop    (wr_drop)
    );

    uft_shifter #(
        .OVS (OVS)
    ) shift_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .tick       (tick_w),
        .len_code   (lc.len_code),
        .long_stop  (lc.long_stop),
        .par_on     (lc.par_on),
        .even_par   (lc.even_par),
        .stick_par  (lc.stick_par),
        .fifo_empty (empty_w),
        .fifo_data  (head_w),
        .pop        (pop_w),
        .line       (line_w),
        .busy       (busy_w)
    );

    // Line gating by break and idle report.
    always_comb begin
        tx      = line_w && !lc.force_break;
        tx_idle = empty_w && !busy_w;
    end

endmodule

// File: rtl/uart_frame_tx_chk.sv
// Module: uart_frame_tx_chk
// Temporal checks on the transmitter ports and its internal baud enable.
module uart_frame_tx_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       wr_en,
    input logic       fifo_full,
    input logic       wr_drop,
    input logic [7:0] line_ctrl,
    input logic       tx,
    input logic       tx_idle,
    input logic       tick
);

    a_r6_break_low: assert property (@(posedge clk) disable iff (!rst_n)
        line_ctrl[6] |-> !tx);

    a_r9_idle_high: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_idle && !line_ctrl[6]) |-> tx);

    a_r8_drop_cause: assert property (@(posedge clk) disable iff (!rst_n)
        wr_drop |-> ($past(fifo_full) && $past(wr_en)));

    a_r8_full_busy: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_full |-> !tx_idle);

    a_r7_edge_on_tick: assert property (@(posedge clk) disable iff (!rst_n)
        (!line_ctrl[6] && !$past(line_ctrl[6]) && (tx != $past(tx))) |-> $past(tick));

    a_r10_hold_no_tick: assert property (@(posedge clk) disable iff (!rst_n)
        $past(line_ctrl[7]) |-> !tick);

endmodule

bind uart_frame_tx uart_frame_tx_chk chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (wr_en),
    .fifo_full (fifo_full),
    .wr_drop   (wr_drop),
    .line_ctrl (line_ctrl),
    .tx        (tx),
    .tx_idle   (tx_idle),
    .tick      (tick_w)
);

// File: tb/uart_frame_tx_tb_top.sv
// Bench: format sweep, divisor sweep, break, timing hold and queue overfill.
module uart_frame_tx_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [7:0]  wr_data = '0;
    logic        fifo_full;
    logic        wr_drop;
    logic [7:0]  line_ctrl = 8'h03;
    logic [15:0] baud_div = 16'd1;
    logic        tx;
    logic        tx_idle;

    int cyc = 0;
    int checks = 0;
    int fails = 0;

    uart_frame_tx dut_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (wr_en),
        .wr_data   (wr_data),
        .fifo_full (fifo_full),
        .wr_drop   (wr_drop),
        .line_ctrl (line_ctrl),
        .baud_div  (baud_div),
        .tx        (tx),
        .tx_idle   (tx_idle)
    );

    always #4 clk = ~clk;

    always @(posedge clk) cyc <= cyc + 1;

    // Watchdog: counts as a failure and still prints the summary.
    always @(posedge clk) begin
        if (cyc > 190000) begin
            fails = fails + 1;
            $display("FAIL watchdog: actual cycle %0d expected below 190000", cyc);
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end

    task automatic check(input string req, input int act, input int exp);
        checks = checks + 1;
        if (act != exp) begin
            fails = fails + 1;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic wait_cyc(input int target);
        while (cyc < target) @(negedge clk);
    endtask

    task automatic push(input logic [7:0] b);
        wr_en   = 1'b1;
        wr_data = b;
        @(negedge clk);
        wr_en   = 1'b0;
    endtask

    function automatic int stop_ticks(input logic [7:0] c);
        if (!c[2]) return 16;
        return (c[1:0] == 2'd0) ? 24 : 32;
    endfunction

    function automatic int frame_ticks(input logic [7:0] c);
        return 16 * (1 + 5 + int'(c[1:0]) + int'(c[3])) + stop_ticks(c);
    endfunction

    // Expected line level in slot k of a frame (R1, R2, R4, R5).
    function automatic int slot_level(input logic [7:0] b, input logic [7:0] c, input int k);
        int n;
        int ones;
        n = 5 + int'(c[1:0]);
        if (k == 0) return 0;
        if (k <= n) return int'(b[k-1]);
        if (c[3] && k == n + 1) begin
            if (c[5]) return c[4] ? 0 : 1;
            ones = 0;
            for (int i = 0; i < n; i++) ones += int'(b[i]);
            return c[4] ? (ones % 2) : 1 - (ones % 2);
        end
        return 1;
    endfunction

    // Find the start edge, then sample each slot in its middle.
    task automatic expect_frame(input logic [7:0] b, input logic [7:0] c,
                                input int d, output int ts);
        int nslots;
        while (tx !== 1'b0) @(negedge clk);
        ts = cyc;
        nslots = 1 + 5 + int'(c[1:0]) + int'(c[3]);
        for (int k = 0; k < nslots; k++) begin
            wait_cyc(ts + (16 * k + 8) * d);
            check(k == 0 ? "R1 start" : "R2/R4/R5 slot", int'(tx), slot_level(b, c, k));
        end
        wait_cyc(ts + (16 * nslots + 8) * d);
        check("R1 stop high", int'(tx), 1);
        wait_cyc(ts + (16 * nslots + stop_ticks(c) - 4) * d);
        check("R3 stop tail high", int'(tx), 1);
    endtask

    task automatic send_pair(input logic [7:0] c, input logic [7:0] b0,
                             input logic [7:0] b1, input int div);
        int d;
        int t0;
        int t1;
        d = (div == 0) ? 1 : div;
        while (!tx_idle) @(negedge clk);
        line_ctrl = c;
        baud_div  = 16'(div);
        push(b0);
        push(b1);
        check("R9 busy after write", int'(tx_idle), 0);
        expect_frame(b0, c, d, t0);
        expect_frame(b1, c, d, t1);
        check("R3 R7 start spacing", t1 - t0, frame_ticks(c) * d);
        while (!tx_idle) @(negedge clk);
        check("R9 idle rise", cyc, t1 + frame_ticks(c) * d);
        check("R1 idle line", int'(tx), 1);
    endtask

    initial begin
        int t0;
        int ts;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 reset tx", int'(tx), 1);
        check("R9 reset idle", int'(tx_idle), 1);
        check("R8 reset full", int'(fifo_full), 0);
        check("R8 reset drop", int'(wr_drop), 0);

        // R2 R3 R4 R5: every format in the low six control bits.
        for (int c = 0; c < 64; c++) begin
            send_pair(8'(c), 8'(8'h5A ^ (c * 7)), 8'(8'hC3 + c * 13), 1);
        end

        // R7: divisor values including zero.
        send_pair(8'h1B, 8'h96, 8'h3C, 0);
        send_pair(8'h2F, 8'hE1, 8'h0F, 3);
        send_pair(8'h0C, 8'h81, 8'h7E, 7);
        send_pair(8'h3F, 8'h55, 8'hAA, 2);

        // R6: break in the middle of a frame, timing kept.
        while (!tx_idle) @(negedge clk);
        line_ctrl = 8'h03;
        baud_div  = 16'd2;
        push(8'hFF);
        while (tx !== 1'b0) @(negedge clk);
        t0 = cyc;
        wait_cyc(t0 + 16 * 3 * 2 + 2);
        line_ctrl = 8'h43;
        for (int k = 3; k < 6; k++) begin
            wait_cyc(t0 + (16 * k + 8) * 2);
            check("R6 break low", int'(tx), 0);
        end
        wait_cyc(t0 + 16 * 6 * 2 + 2);
        line_ctrl = 8'h03;
        for (int k = 6; k < 10; k++) begin
            wait_cyc(t0 + (16 * k + 8) * 2);
            check("R6 slot after break", int'(tx), 1);
        end
        while (!tx_idle) @(negedge clk);
        check("R6 frame end kept", cyc, t0 + 160 * 2);

        // R10: timing hold freezes a waiting byte.
        line_ctrl = 8'h83;
        baud_div  = 16'd1;
        push(8'h6D);
        for (int i = 0; i < 400; i++) begin
            @(negedge clk);
            if (tx !== 1'b1) check("R10 held line", int'(tx), 1);
        end
        check("R10 still queued", int'(tx_idle), 0);
        line_ctrl = 8'h03;
        expect_frame(8'h6D, 8'h03, 1, ts);
        while (!tx_idle) @(negedge clk);

        // R8: overfill while one frame is on the line.
        push(8'h11);
        while (tx !== 1'b0) @(negedge clk);
        t0 = cyc;
        for (int i = 0; i < 17; i++) begin
            wr_en   = 1'b1;
            wr_data = 8'(8'h20 + i);
            @(negedge clk);
            if (i == 15) check("R8 full at 16", int'(fifo_full), 1);
            if (i == 16) check("R8 drop pulse", int'(wr_drop), 1);
        end
        wr_en = 1'b0;
        @(negedge clk);
        check("R8 drop one cycle", int'(wr_drop), 0);
        wait_cyc(t0 + 150);
        for (int i = 0; i < 16; i++) begin
            expect_frame(8'(8'h20 + i), 8'h03, 1, ts);
            if (i == 0) check("R3 back to back", ts - t0, 160);
        end
        while (!tx_idle) @(negedge clk);
        for (int i = 0; i < 300; i++) begin
            @(negedge clk);
            if (tx !== 1'b1) check("R8 dropped byte not sent", int'(tx), 1);
        end
        check("R8 queue drained", int'(tx_idle), 1);

        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

endmodule